// File: doc/BRIEF.md
# Slave FIFO Packet Write Master

This block is the master side of a synchronous slave FIFO on a USB peripheral controller. It takes a stream of elements (bytes or words) on a valid/ready input, where a last marker closes each packet. On the FIFO side it drives the FIFO select address, the write strobe, the data bus and the packet-end strobe, all relative to the interface clock. An element is accepted and written in the same clock, so the write strobe equals the input handshake. Writing pauses while the slave reports full.

The slave commits a packet by itself each time its element count reaches a programmed auto-commit length. The master keeps its own count of written elements modulo that length, so it knows where each automatic commit falls. A packet whose last element lands on such a boundary needs no further action. A shorter tail is committed by pulsing packet-end together with its last write. One case needs special handling: a tail of exactly one element written straight after an automatic commit. For that case the master writes the element with no packet-end, stalls the input for one clock, and only then raises packet-end. This timing is required; if the slave sees packet-end too early, the one-element packet is lost.

Top module: `sfifo_pkt_writer`

## Requirements
- R1: Each element accepted on the input (`s_valid` and `s_ready` both high) is written in that same clock, with `fifo_wr` high and `fifo_data` equal to `s_data`. While `fifo_full` is high, `s_ready` and `fifo_wr` stay low.
- R2: The master counts written elements modulo `cfg_auto_len`. The write of element number `cfg_auto_len` (and of every later multiple) is a boundary. A packet whose last element is written on a boundary produces no `fifo_pktend` pulse.
- R3: A tail that is not on a boundary and is two or more elements long gets `fifo_pktend` high in the same clock as its last write.
- R4: Take a one-element tail whose write comes directly after a boundary write. It is written with `fifo_pktend` low. In the next clock `fifo_pktend` is high, `s_ready` is low and `fifo_wr` is low. In the clock after that, `fifo_pktend` is low again.
- R5: If `fifo_full` is high while a deferred packet-end from R4 is waiting, `fifo_pktend` and `s_ready` stay low. `fifo_pktend` goes high in the first clock in which `fifo_full` is low.
- R6: `fifo_addr` takes the value of `cfg_fifo_sel` as it was before the first element of a packet. It holds that value through the whole packet, including a deferred packet-end, even if `cfg_fifo_sel` changes meanwhile.
- R7: While `rst_n` is low, `s_ready`, `fifo_wr` and `fifo_pktend` are low. Reset also clears the element count, so the next packet's boundary falls at element `cfg_auto_len`.
- R8: A packet-end commit restarts the element count at zero. The next boundary therefore falls `cfg_auto_len` writes after the commit.
- R9: A one-element packet that follows a manual commit, or follows reset, gets `fifo_pktend` in the same clock as its write, with no gap.
- R10: The auto-commit length comes from the `cfg_auto_len` input. Changing it between packets, while the count is zero, moves every later boundary to the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_auto_len | input | CNT_W | Auto-commit length in elements (at least 1) |
| cfg_fifo_sel | input | ADDR_W | FIFO select used for the next packet |
| s_valid | input | 1 | Input element valid |
| s_ready | output | 1 | Input element accepted this clock |
| s_data | input | DATA_W | Input element |
| s_last | input | 1 | Element closes its packet |
| fifo_full | input | 1 | Slave full flag, active high, synchronous to clk |
| fifo_addr | output | ADDR_W | FIFO select address |
| fifo_wr | output | 1 | Write strobe, active high |
| fifo_data | output | DATA_W | Write data |
| fifo_pktend | output | 1 | Packet-end strobe, active high |

## Verification
The assertions assume that `fifo_full` is already synchronous to the interface clock. They also assume that `cfg_auto_len` changes only while the element count is zero, since a count left over from an old length has no defined meaning. The stimulus drives every input on the falling clock edge and changes the length only between committed packets. It holds `cfg_fifo_sel` steady for at least one clock before each packet starts, and moves it only while a packet is in progress, to show that the address holds.

// File: rtl/sfpw_pkg.sv
package sfpw_pkg;

  typedef enum logic [0:0] {
    ST_RUN = 1'b0,
    ST_GAP = 1'b1
  } wr_state_e;

endpackage

// File: rtl/sfpw_elem_count.sv
module sfpw_elem_count #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             commit,
  input  logic [CNT_W-1:0] auto_len,
  output logic [CNT_W-1:0] count,
  output logic             at_boundary,
  output logic             after_auto
);

  logic [CNT_W-1:0] count_q, count_n;
  logic             auto_q, auto_n;
  logic             bnd;

  assign bnd = (count_q >= (auto_len - 1'b1));

  always_comb begin
    count_n = count_q;
    auto_n  = auto_q;
    if (wr_en) begin
      if (bnd) begin
        count_n = '0;
        auto_n  = 1'b1;
      end else begin
        count_n = count_q + 1'b1;
        auto_n  = 1'b0;
      end
    end
    if (commit) begin
      count_n = '0;
      auto_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      auto_q  <= 1'b0;
    end else if (wr_en || commit) begin
      count_q <= count_n;
      auto_q  <= auto_n;
    end
  end

  assign count       = count_q;
  assign at_boundary = bnd;
  assign after_auto  = auto_q;

endmodule

// File: rtl/sfpw_commit_ctl.sv
module sfpw_commit_ctl
  import sfpw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_ok,
  input  logic s_valid,
  input  logic s_last,
  input  logic fifo_full,
  input  logic at_boundary,
  input  logic after_auto,
  output logic s_ready,
  output logic wr_fire,
  output logic pktend,
  output logic gap_active
);

  wr_state_e state_q, state_n;
  logic      defer;

  assign s_ready = run_ok && (state_q == ST_RUN) && !fifo_full;
  assign wr_fire = s_valid && s_ready;
  assign defer   = wr_fire && s_last && after_auto && !at_boundary;

  always_comb begin
    if (state_q == ST_GAP) begin
      pktend = !fifo_full;
    end else begin
      pktend = wr_fire && s_last && !at_boundary && !after_auto;
    end
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN: if (defer) state_n = ST_GAP;
      ST_GAP: if (!fifo_full) state_n = ST_RUN;
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_n;
    end
  end

  assign gap_active = (state_q == ST_GAP);

endmodule

// File: rtl/sfpw_addr_hold.sv
module sfpw_addr_hold #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              s_last,
  input  logic              gap_active,
  input  logic [ADDR_W-1:0] sel_in,
  output logic [ADDR_W-1:0] addr
);

  logic              in_pkt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hold;

  assign hold = in_pkt_q || gap_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
    end else if (wr_fire) begin
      in_pkt_q <= !s_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (!hold) begin
      addr_q <= sel_in;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/sfifo_pkt_writer.sv
module sfifo_pkt_writer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_auto_len,
  input  logic [ADDR_W-1:0] cfg_fifo_sel,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              fifo_full,
  output logic [ADDR_W-1:0] fifo_addr,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pktend
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_core_n;
  logic                   wr_fire;
  logic                   pktend_w;
  logic                   gap_w;
  logic [CNT_W-1:0]       count_w;
  logic                   at_bnd_w;
  logic                   after_auto_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[SYNC_STAGES-1];

  sfpw_elem_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_fire),
    .commit      (pktend_w),
    .auto_len    (cfg_auto_len),
    .count       (count_w),
    .at_boundary (at_bnd_w),
    .after_auto  (after_auto_w)
  );

  sfpw_commit_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .run_ok      (rst_core_n),
    .s_valid     (s_valid),
    .s_last      (s_last),
    .fifo_full   (fifo_full),
    .at_boundary (at_bnd_w),
    .after_auto  (after_auto_w),
    .s_ready     (s_ready),
    .wr_fire     (wr_fire),
    .pktend      (pktend_w),
    .gap_active  (gap_w)
  );

  sfpw_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_fire    (wr_fire),
    .s_last     (s_last),
    .gap_active (gap_w),
    .sel_in     (cfg_fifo_sel),
    .addr       (fifo_addr)
  );

  assign fifo_wr     = wr_fire;
  assign fifo_data   = s_data;
  assign fifo_pktend = pktend_w;

endmodule

// File: rtl/sfpw_chk.sv
module sfpw_chk #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic              s_ready,
  input logic              s_last,
  input logic              fifo_full,
  input logic [ADDR_W-1:0] fifo_addr,
  input logic              fifo_wr,
  input logic              fifo_pktend,
  input logic [CNT_W-1:0]  count,
  input logic              at_boundary
);

  p_wr_blocked_full_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    fifo_full |-> !fifo_wr);

  p_boundary_wrap_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fifo_wr && at_boundary) |=> (count == '0));

  p_no_pktend_on_boundary_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fifo_wr && at_boundary) |-> !fifo_pktend);

  p_gap_after_auto_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fifo_wr && at_boundary) |=> !fifo_pktend);

  p_single_deferred_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fifo_wr && s_last && !fifo_pktend && !at_boundary) |=>
      (!fifo_wr && !s_ready && (fifo_pktend || fifo_full)));

  p_pend_held_full_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    fifo_full |-> !fifo_pktend);

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (fifo_wr && !s_last) |=> $stable(fifo_addr));

  p_count_restart_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    fifo_pktend |=> (count == '0));

  // R7: quiet strobes while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r7: assert (!fifo_wr && !fifo_pktend && !s_ready);
    end
  end

endmodule

bind sfifo_pkt_writer sfpw_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_rst_n  (rst_core_n),
  .s_ready     (s_ready),
  .s_last      (s_last),
  .fifo_full   (fifo_full),
  .fifo_addr   (fifo_addr),
  .fifo_wr     (fifo_wr),
  .fifo_pktend (fifo_pktend),
  .count       (count_w),
  .at_boundary (at_bnd_w)
);

// File: tb/sfifo_pkt_writer_tb_top.sv
module sfifo_pkt_writer_tb_top;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 10;

  logic              clk;
  logic              rst_n;
  logic [CNT_W-1:0]  cfg_auto_len;
  logic [ADDR_W-1:0] cfg_fifo_sel;
  logic              s_valid;
  logic              s_ready;
  logic [DATA_W-1:0] s_data;
  logic              s_last;
  logic              fifo_full;
  logic [ADDR_W-1:0] fifo_addr;
  logic              fifo_wr;
  logic [DATA_W-1:0] fifo_data;
  logic              fifo_pktend;

  int n_checks = 0;
  int n_fails  = 0;
  int m_cnt    = 0;
  bit m_auto   = 1'b0;
  int dval     = 16'h100;
  bit finished = 1'b0;

  sfifo_pkt_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_auto_len (cfg_auto_len),
    .cfg_fifo_sel (cfg_fifo_sel),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .s_data       (s_data),
    .s_last       (s_last),
    .fifo_full    (fifo_full),
    .fifo_addr    (fifo_addr),
    .fifo_wr      (fifo_wr),
    .fifo_data    (fifo_data),
    .fifo_pktend  (fifo_pktend)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    s_valid = 1'b0;
    s_last  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cnt  = 0;
    m_auto = 1'b0;
  endtask

  // Drives one packet of n elements; expectations come from the bench model
  task automatic send_pkt(input int n, input int stall_at, input int gap_full,
                          input bit move_sel, input string req);
    logic [ADDR_W-1:0] exp_addr;
    int  x;
    bit  deferred;
    x        = int'(cfg_auto_len);
    exp_addr = cfg_fifo_sel;
    deferred = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit    last;
      bit    bnd;
      bit    exp_pe;
      string tag;
      last = (i == n - 1);
      bnd  = (m_cnt == x - 1);
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = DATA_W'(dval);
      s_last  = last;
      if (move_sel && i == 1) cfg_fifo_sel = ~cfg_fifo_sel;
      if (i == stall_at) begin
        fifo_full = 1'b1;
        #2;
        chk(s_ready === 1'b0, "R1", "ready while full", s_ready, 0);
        chk(fifo_wr === 1'b0, "R1", "write while full", fifo_wr, 0);
        @(negedge clk);
        fifo_full = 1'b0;
      end
      #2;
      deferred = last && m_auto && !bnd;
      exp_pe   = last && !bnd && !m_auto;
      tag = (last && bnd) ? "R2" : (deferred ? "R4" : req);
      chk(fifo_wr === 1'b1, "R1", "write strobe", fifo_wr, 1);
      chk(fifo_data === DATA_W'(dval), "R1", "write data", fifo_data, dval);
      chk(fifo_pktend === exp_pe, tag, "pktend with write", fifo_pktend, exp_pe);
      chk(fifo_addr === exp_addr, "R6", "address in packet", fifo_addr, exp_addr);
      dval++;
      if (bnd) begin
        m_cnt = 0; m_auto = 1'b1;
      end else begin
        m_cnt++; m_auto = 1'b0;
      end
      if (exp_pe) begin
        m_cnt = 0; m_auto = 1'b0;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    if (deferred) begin
      if (move_sel) cfg_fifo_sel = ~cfg_fifo_sel;
      if (gap_full > 0) begin
        fifo_full = 1'b1;
        for (int k = 0; k < gap_full; k++) begin
          #2;
          chk(fifo_pktend === 1'b0, "R5", "pktend while full", fifo_pktend, 0);
          chk(s_ready === 1'b0, "R5", "ready while pending", s_ready, 0);
          @(negedge clk);
        end
        fifo_full = 1'b0;
      end
      #2;
      chk(fifo_pktend === 1'b1, gap_full > 0 ? "R5" : "R4", "deferred pktend", fifo_pktend, 1);
      chk(s_ready === 1'b0, "R4", "ready in gap", s_ready, 0);
      chk(fifo_wr === 1'b0, "R4", "write in gap", fifo_wr, 0);
      chk(fifo_addr === exp_addr, "R6", "address in gap", fifo_addr, exp_addr);
      m_cnt = 0; m_auto = 1'b0;
      @(negedge clk);
      #2;
      chk(fifo_pktend === 1'b0, "R4", "pktend after gap", fifo_pktend, 0);
    end
  endtask

  task automatic t_reset();
    rst_n        = 1'b0;
    s_valid      = 1'b1;
    s_data       = '0;
    s_last       = 1'b1;
    fifo_full    = 1'b0;
    cfg_auto_len = CNT_W'(4);
    cfg_fifo_sel = ADDR_W'(1);
    repeat (2) @(negedge clk);
    #2;
    chk(s_ready === 1'b0, "R7", "ready in reset", s_ready, 0);
    chk(fifo_wr === 1'b0, "R7", "write in reset", fifo_wr, 0);
    chk(fifo_pktend === 1'b0, "R7", "pktend in reset", fifo_pktend, 0);
    s_valid = 1'b0;
    s_last  = 1'b0;
    rst_n   = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_boundary_then_single();
    send_pkt(8, -1, 0, 1'b0, "R2");
    send_pkt(1, -1, 0, 1'b0, "R4");
  endtask

  task automatic t_fresh_single();
    send_pkt(1, -1, 0, 1'b0, "R9");
  endtask

  task automatic t_tail_with_stall();
    send_pkt(6, 3, 0, 1'b1, "R3");
    send_pkt(4, -1, 0, 1'b0, "R8");
  endtask

  task automatic t_gap_full();
    send_pkt(5, -1, 2, 1'b1, "R5");
  endtask

  task automatic t_new_length();
    cfg_auto_len = CNT_W'(3);
    @(negedge clk);
    send_pkt(7, -1, 0, 1'b0, "R10");
    send_pkt(2, -1, 0, 1'b0, "R10");
  endtask

  task automatic t_reset_clears_count();
    cfg_auto_len = CNT_W'(4);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = DATA_W'(dval);
      s_last  = 1'b0;
      dval++;
    end
    do_reset();
    send_pkt(4, -1, 0, 1'b0, "R7");
    send_pkt(1, -1, 0, 1'b0, "R4");
  endtask

  initial begin
    t_reset();
    t_boundary_then_single();
    t_fresh_single();
    t_tail_with_stall();
    t_gap_full();
    t_new_length();
    t_reset_clears_count();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule